// File: doc/BRIEF.md
# Line-Scan Spatio-Temporal Pixel Smoother

The block conditions a stream of line-scan pixels before any edge search runs on it. Each frame is a single line of pixels. The block first smooths each pixel with a box average over a short window of its neighbours in the same line. It then averages that result with the smoothed values that held the same pixel index in the most recent earlier frames. Noise that varies from pixel to pixel and from frame to frame is reduced, while a stationary edge keeps its position.

Pixels arrive with a valid strobe and an end-of-frame marker on the last pixel of each line. One smoothed pixel leaves for each pixel that enters, two cycles later, with the marker carried alongside. Earlier frames are held as one memory word per pixel index. Until enough frames have been seen to fill the time window, the block forwards the spatially smoothed value and keeps a settled flag low.

Top module: `line_smoother`

## Requirements
- R1: While reset is held and immediately after it, out_valid, out_eof and out_settled are 0.
- R2: Each pixel accepted with in_valid=1 produces exactly one output with out_valid=1, two clock cycles after the edge that sampled it. out_valid is never 1 without such an input, and idle cycles between pixels are allowed.
- R3: A pixel whose index within its line is below BOX_TAPS-1 (0 to 6 by default) leaves the spatial stage unchanged. Index 0 is the first pixel after reset or after an end-of-frame pixel.
- R4: From index BOX_TAPS-1 onward, the spatial value is floor(sum of the current pixel and the BOX_TAPS-1 preceding pixels of the same line / BOX_TAPS).
- R5: The spatial window never reaches across a frame boundary. After a pixel with in_eof=1 the index restarts at 0, including after a frame shorter than the window.
- R6: out_settled is 0 for every pixel of the first WIN_FRAMES-1 frames after reset (3 by default). For those pixels out_pix equals the spatial value.
- R7: For every pixel of a later frame, out_settled is 1 and out_pix = floor((spatial value + the WIN_FRAMES-1 most recent spatial values produced at the same pixel index) / WIN_FRAMES).
- R8: Once out_settled has gone to 1, it stays 1 until reset.
- R9: out_eof is 1 exactly on the output that belongs to the input pixel carrying in_eof, and only when out_valid is 1.
- R10: Frames of a single pixel that follow each other with no idle cycle are averaged correctly, even though the memory is read and written at the same index in the same cycle.
- R11: Idle cycles inside a frame do not change any output value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel strobe |
| in_pix | input | PIX_W | Input pixel intensity |
| in_eof | input | 1 | Marks the last pixel of a frame |
| out_valid | output | 1 | Output pixel strobe |
| out_pix | output | PIX_W | Smoothed pixel |
| out_eof | output | 1 | Last smoothed pixel of a frame |
| out_settled | output | 1 | Time window holds enough earlier frames |

## Verification
Two things can land in the same cycle. The stored-frame memory can be written at one pixel index while it is read for the next incoming pixel at the same index, and a line restart can coincide with a memory update. The first case is provoked with back-to-back one-pixel frames, where every write and read target index 0 in the same cycle. The second case is provoked by a five-pixel frame followed at once by a full frame. A bench model keeps its own per-index history and judges every output value, marker and flag against it. The stimulus also sweeps ramp, saturated, alternating and pseudo-random lines, and gapped input, over a 16-pixel line configuration.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    localparam int PIX_W_DEF      = 8;
    localparam int LINE_LEN_DEF   = 1024;
    localparam int BOX_TAPS_DEF   = 8;
    localparam int WIN_FRAMES_DEF = 4;

    // phase of the temporal window
    typedef enum logic {
        WIN_WARM    = 1'b0,
        WIN_SETTLED = 1'b1
    } win_state_e;
endpackage

// File: rtl/lsm_line_ram.sv
module lsm_line_ram #(
    parameter int WORD_W = 24,
    parameter int DEPTH  = 1024,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data
);
    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [WORD_W-1:0] rd_data_q;

    // read-first: a same-address write is not visible in this read
    always_ff @(posedge clk) begin
        if (rd_en)
            rd_data_q <= mem_q[rd_addr];
        if (wr_en)
            mem_q[wr_addr] <= wr_data;
    end

    assign rd_data = rd_data_q;
endmodule

// File: rtl/lsm_box_filter.sv
module lsm_box_filter #(
    parameter int PIX_W    = lsm_pkg::PIX_W_DEF,
    parameter int LINE_LEN = lsm_pkg::LINE_LEN_DEF,
    parameter int TAPS     = lsm_pkg::BOX_TAPS_DEF,
    localparam int SH      = $clog2(TAPS),
    localparam int SUM_W   = PIX_W + SH,
    localparam int IDX_W   = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1,
    localparam int FILL_W  = (SH > 0) ? SH : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pix,
    input  logic             in_eof,
    output logic [IDX_W-1:0] cur_idx,
    output logic             s_valid,
    output logic [PIX_W-1:0] s_pix,
    output logic [IDX_W-1:0] s_idx,
    output logic             s_eof
);
    typedef struct packed {
        logic [TAPS-1:0][PIX_W-1:0] hist;
        logic [SUM_W-1:0]           sum;
        logic [IDX_W-1:0]           idx;
        logic [FILL_W-1:0]          fill;
        logic                       s_valid;
        logic [PIX_W-1:0]           s_pix;
        logic [IDX_W-1:0]           s_idx;
        logic                       s_eof;
    } box_st_t;

    box_st_t st_q, st_d;
    logic [SUM_W-1:0] new_sum;
    logic             win_full;

    always_comb begin
        st_d     = st_q;
        new_sum  = st_q.sum + SUM_W'(in_pix) - SUM_W'(st_q.hist[TAPS-1]);
        win_full = (st_q.fill == FILL_W'(TAPS-1));
        st_d.s_valid = in_valid;
        st_d.s_eof   = 1'b0;
        if (in_valid) begin
            st_d.s_pix = win_full ? PIX_W'(new_sum >> SH) : in_pix;
            st_d.s_idx = st_q.idx;
            st_d.s_eof = in_eof;
            if (in_eof) begin
                st_d.hist = '0;
                st_d.sum  = '0;
                st_d.idx  = '0;
                st_d.fill = '0;
            end else begin
                for (int i = TAPS-1; i > 0; i--)
                    st_d.hist[i] = st_q.hist[i-1];
                st_d.hist[0] = in_pix;
                st_d.sum     = new_sum;
                st_d.idx     = (st_q.idx == IDX_W'(LINE_LEN-1)) ? '0 : st_q.idx + 1'b1;
                if (!win_full)
                    st_d.fill = st_q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign cur_idx = st_q.idx;
    assign s_valid = st_q.s_valid;
    assign s_pix   = st_q.s_pix;
    assign s_idx   = st_q.s_idx;
    assign s_eof   = st_q.s_eof;

    // R3
    head_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid && (s_idx < IDX_W'(TAPS-1)) |-> s_pix == $past(in_pix));

    // R5
    line_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_eof |=> cur_idx == '0);
endmodule

// File: rtl/lsm_frame_avg.sv
module lsm_frame_avg #(
    parameter int PIX_W      = lsm_pkg::PIX_W_DEF,
    parameter int LINE_LEN   = lsm_pkg::LINE_LEN_DEF,
    parameter int WIN_FRAMES = lsm_pkg::WIN_FRAMES_DEF,
    localparam int WSH       = $clog2(WIN_FRAMES),
    localparam int HIST      = WIN_FRAMES - 1,
    localparam int ACC_W     = PIX_W + WSH,
    localparam int IDX_W     = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1,
    localparam int CNT_W     = (WSH > 0) ? WSH : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             s_valid,
    input  logic [PIX_W-1:0] s_pix,
    input  logic [IDX_W-1:0] s_idx,
    input  logic             s_eof,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix,
    output logic             out_eof,
    output logic             out_settled
);
    import lsm_pkg::*;

    typedef logic [HIST-1:0][PIX_W-1:0] word_t;

    typedef struct packed {
        win_state_e       state;
        logic [CNT_W-1:0] frames;
        logic             fwd;
        word_t            fwd_word;
        logic             out_valid;
        logic [PIX_W-1:0] out_pix;
        logic             out_eof;
        logic             out_settled;
    } avg_st_t;

    avg_st_t st_q, st_d;
    word_t   ram_word;
    word_t   old_word;
    word_t   new_word;
    logic [ACC_W-1:0] acc;

    lsm_line_ram #(
        .WORD_W (HIST*PIX_W),
        .DEPTH  (LINE_LEN)
    ) u_store (
        .clk     (clk),
        .rd_en   (rd_en),
        .rd_addr (rd_idx),
        .rd_data (ram_word),
        .wr_en   (s_valid),
        .wr_addr (s_idx),
        .wr_data (new_word)
    );

    always_comb begin
        st_d     = st_q;
        old_word = st_q.fwd ? st_q.fwd_word : ram_word;
        acc      = ACC_W'(s_pix);
        for (int i = 0; i < HIST; i++)
            acc = acc + ACC_W'(old_word[i]);
        new_word[0] = s_pix;
        for (int i = 1; i < HIST; i++)
            new_word[i] = old_word[i-1];

        // same-index write and read in one cycle: forward the write
        st_d.fwd      = rd_en && s_valid && (rd_idx == s_idx);
        st_d.fwd_word = new_word;

        st_d.out_valid = s_valid;
        st_d.out_eof   = 1'b0;
        if (s_valid) begin
            st_d.out_pix     = (st_q.state == WIN_SETTLED) ? PIX_W'(acc >> WSH) : s_pix;
            st_d.out_eof     = s_eof;
            st_d.out_settled = (st_q.state == WIN_SETTLED);
            if (s_eof && st_q.state == WIN_WARM) begin
                if (st_q.frames == CNT_W'(WIN_FRAMES-2))
                    st_d.state = WIN_SETTLED;
                else
                    st_d.frames = st_q.frames + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid   = st_q.out_valid;
    assign out_pix     = st_q.out_pix;
    assign out_eof     = st_q.out_eof;
    assign out_settled = st_q.out_settled;

    // R8
    settled_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_settled |=> out_settled);

    // R6
    warm_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_settled |-> out_pix == $past(s_pix));
endmodule

// File: rtl/line_smoother.sv
module line_smoother #(
    parameter int PIX_W      = lsm_pkg::PIX_W_DEF,
    parameter int LINE_LEN   = lsm_pkg::LINE_LEN_DEF,
    parameter int BOX_TAPS   = lsm_pkg::BOX_TAPS_DEF,
    parameter int WIN_FRAMES = lsm_pkg::WIN_FRAMES_DEF,
    localparam int IDX_W     = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pix,
    input  logic             in_eof,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix,
    output logic             out_eof,
    output logic             out_settled
);
    logic [IDX_W-1:0] cur_idx;
    logic             s_valid;
    logic [PIX_W-1:0] s_pix;
    logic [IDX_W-1:0] s_idx;
    logic             s_eof;

    lsm_box_filter #(
        .PIX_W    (PIX_W),
        .LINE_LEN (LINE_LEN),
        .TAPS     (BOX_TAPS)
    ) u_box (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_pix   (in_pix),
        .in_eof   (in_eof),
        .cur_idx  (cur_idx),
        .s_valid  (s_valid),
        .s_pix    (s_pix),
        .s_idx    (s_idx),
        .s_eof    (s_eof)
    );

    lsm_frame_avg #(
        .PIX_W      (PIX_W),
        .LINE_LEN   (LINE_LEN),
        .WIN_FRAMES (WIN_FRAMES)
    ) u_avg (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (in_valid),
        .rd_idx      (cur_idx),
        .s_valid     (s_valid),
        .s_pix       (s_pix),
        .s_idx       (s_idx),
        .s_eof       (s_eof),
        .out_valid   (out_valid),
        .out_pix     (out_pix),
        .out_eof     (out_eof),
        .out_settled (out_settled)
    );

    // R9
    eof_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> out_valid);

    // R2
    two_cycle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));
endmodule

// File: tb/line_smoother_bench.sv
module line_smoother_bench;
    localparam int LL = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [7:0] in_pix;
    logic       in_eof;
    logic       out_valid;
    logic [7:0] out_pix;
    logic       out_eof;
    logic       out_settled;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // bench model state
    int    m_idx = 0;
    int    m_win [8];
    int    m_hist [LL][3];
    int    m_done = 0;
    string tag_ovr = "";
    logic [7:0] lfsr = 8'h5A;

    int    q_due [$];
    int    q_pix [$];
    int    q_eof [$];
    int    q_set [$];
    string q_tag [$];

    line_smoother #(.LINE_LEN(LL)) u_line_smoother (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_pix      (in_pix),
        .in_eof      (in_eof),
        .out_valid   (out_valid),
        .out_pix     (out_pix),
        .out_eof     (out_eof),
        .out_settled (out_settled)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    task automatic monitor();
        if (q_due.size() > 0 && q_due[0] == cyc) begin
            check("R2", int'(out_valid), 1);
            check(q_tag[0], int'(out_pix), q_pix[0]);
            check("R9", int'(out_eof), q_eof[0]);
            check(q_set[0] != 0 ? "R8" : "R6", int'(out_settled), q_set[0]);
            void'(q_due.pop_front()); void'(q_pix.pop_front());
            void'(q_eof.pop_front()); void'(q_set.pop_front());
            void'(q_tag.pop_front());
        end else if (out_valid) begin
            check("R2", int'(out_valid), 0);
        end
    endtask

    task automatic step();
        @(negedge clk);
        monitor();
    endtask

    function automatic logic [7:0] next_rand();
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        return lfsr;
    endfunction

    task automatic send(input int pix, input bit eof);
        int sp, sum, ex, idx;
        bit settled;
        string tg;
        step();
        in_valid = 1'b1;
        in_pix   = 8'(pix);
        in_eof   = eof;
        idx = m_idx;
        for (int i = 7; i > 0; i--) m_win[i] = m_win[i-1];
        m_win[0] = pix;
        sum = 0;
        for (int i = 0; i < 8; i++) sum += m_win[i];
        sp = (idx < 7) ? pix : (sum >> 3);
        settled = (m_done >= 3);
        ex = settled ? ((sp + m_hist[idx][0] + m_hist[idx][1] + m_hist[idx][2]) >> 2) : sp;
        m_hist[idx][2] = m_hist[idx][1];
        m_hist[idx][1] = m_hist[idx][0];
        m_hist[idx][0] = sp;
        if (tag_ovr != "") tg = tag_ovr;
        else if (settled) tg = "R7";
        else tg = (idx < 7) ? "R3" : "R4";
        q_due.push_back(cyc + 2);
        q_pix.push_back(ex);
        q_eof.push_back(int'(eof));
        q_set.push_back(int'(settled));
        q_tag.push_back(tg);
        if (eof) begin
            m_idx = 0;
            m_done++;
            for (int i = 0; i < 8; i++) m_win[i] = 0;
        end else begin
            m_idx++;
        end
    endtask

    task automatic idle();
        step();
        in_valid = 1'b0;
        in_eof   = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_win[i] = 0;
        for (int a = 0; a < LL; a++)
            for (int j = 0; j < 3; j++) m_hist[a][j] = 0;
        rst_n = 1'b0; in_valid = 1'b0; in_pix = '0; in_eof = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_eof), 0);
        check("R1", int'(out_settled), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(out_valid), 0);

        // ramp, saturated, random, alternating
        for (int i = 0; i < LL; i++) send(i * 13, i == LL-1);
        for (int i = 0; i < LL; i++) send(255, i == LL-1);
        for (int i = 0; i < LL; i++) send(next_rand(), i == LL-1);
        for (int i = 0; i < LL; i++) send((i % 2) ? 255 : 0, i == LL-1);
        // gapped frame
        tag_ovr = "R11";
        for (int i = 0; i < LL; i++) begin
            send(next_rand(), i == LL-1);
            if (i % 3 == 0) idle();
            if (i % 5 == 0) begin idle(); idle(); end
        end
        tag_ovr = "";
        for (int i = 0; i < LL; i++) send(next_rand(), i == LL-1);
        // short frame then full frame
        tag_ovr = "R5";
        for (int i = 0; i < 5; i++) send(next_rand(), i == 4);
        for (int i = 0; i < LL; i++) send(next_rand(), i == LL-1);
        // back-to-back one-pixel frames
        tag_ovr = "R10";
        for (int k = 0; k < 6; k++) send(next_rand(), 1'b1);
        tag_ovr = "";
        for (int i = 0; i < LL; i++) send(next_rand(), i == LL-1);
        repeat (6) idle();
        check("R2", q_due.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule